// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the results of instructions that have left execution but have not yet retired in an out-of-order core. The front end reserves one slot per instruction in program order and receives the slot index as a tag. Functional units later deliver a result to a slot by that tag. The oldest slot retires once its result has arrived. When it retires, it updates the architectural register file through the commit port, at most one register per cycle.

The slots also act as rename tags. A lookup port takes a register number and searches the younger in-flight producers of that register. It returns the newest one: the value if that producer has finished, or the producer's tag if it has not. A branch whose result is flagged as mispredicted retires normally. In the same cycle it raises a flush, and the flush throws away every younger slot without any register update.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, commit_fire and flush are 0, and a lookup never hits.
- R2: Each accepted allocation (alloc_valid and alloc_ready both high at a clock edge) takes the slot shown on alloc_tag. Tags advance by one, modulo DEPTH, in program order.
- R3: With DEPTH slots occupied, alloc_ready is 0. A request made while full is dropped, and alloc_tag does not move.
- R4: A writeback marks the addressed slot finished and stores its value. A writeback to a tag that holds no live slot is ignored, and a slot allocated there later still reads as unfinished.
- R5: Only the oldest slot retires. It retires in the cycle after its result arrives, while younger finished slots wait. At most one slot retires per cycle.
- R6: A retiring slot of kind 0 (register result) raises commit_wr with its destination and value. Kind 1 (branch) and kind 2 (store) retire with commit_wr low.
- R7: A lookup hits on the youngest live kind-0 slot whose destination matches. It returns lookup_ready=1 and the value if that slot is finished, and otherwise lookup_ready=0 and its tag.
- R8: Once a producer has retired and no younger producer of that register is live, a lookup of the register no longer hits.
- R9: A finished branch at the oldest position carrying the mispredict flag retires with flush=1. In that cycle alloc_ready is 0 and an allocation request is dropped. All younger slots are discarded without retiring. The next tag issued is the branch tag plus one.
- R10: An allocation and a retirement in the same cycle both take effect, so occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request for a new slot |
| alloc_kind | input | 2 | Instruction kind: 0 register result, 1 branch, 2 store |
| alloc_dest | input | 5 | Destination register of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag the next accepted allocation receives |
| wb_valid | input | 1 | Result delivery strobe |
| wb_tag | input | log2(DEPTH) | Slot receiving the result |
| wb_value | input | 32 | Result value |
| wb_mispred | input | 1 | Branch outcome disagreed with the prediction |
| lookup_reg | input | 5 | Register searched for a pending producer |
| lookup_hit | output | 1 | A live producer exists |
| lookup_ready | output | 1 | That producer has finished |
| lookup_tag | output | log2(DEPTH) | Tag of that producer |
| lookup_value | output | 32 | Its value when finished |
| commit_fire | output | 1 | Oldest slot retires this cycle |
| commit_wr | output | 1 | Retirement writes a register |
| commit_reg | output | 5 | Register written |
| commit_value | output | 32 | Value written |
| flush | output | 1 | Mispredicted branch retiring; younger work discarded |

## Verification
Two cases can fall in the same cycle, and the bench provokes both. In the first, allocation coincides with retirement. The bench fills the buffer, retires one slot and then finishes the next head. It issues a new allocation in exactly the cycle that head retires, then checks that the tag advanced once and that the buffer still accepts requests. In the second, a flush coincides with a request. The bench holds alloc_valid high in the cycle a mispredicted branch retires and confirms afterwards that the request's destination is unknown to lookup and that the tag restarts after the branch. Retirements are judged against a scoreboard queue filled in program order, so a squashed or reordered retirement shows up as a mismatch or an unexpected entry.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_STORE  = 2'd2
    } rob_kind_e;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              mispred;
        rob_kind_e         kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
    } rob_slot_t;

    function automatic logic writes_reg(input rob_slot_t s);
        return s.kind == KIND_REG;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic             commit_fire,
    input  logic             flush,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             full
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= head + 1'b1;
            tail  <= head + 1'b1;
            count <= '0;
        end else begin
            if (commit_fire) head <= head + 1'b1;
            if (alloc_fire)  tail <= tail + 1'b1;
            case ({alloc_fire, commit_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CNT_W'(DEPTH));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2
    ptr_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        PTR_W'(tail - head) == count[PTR_W-1:0]);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0) && (tail == head));

    // R5
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        commit_fire |=> head == PTR_W'($past(head) + 1'b1));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_fire && commit_fire && !flush) |=> count == $past(count));

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [PTR_W-1:0]  tail,
    input  rob_kind_e         alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_valid,
    input  logic [PTR_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mispred,
    input  logic              commit_fire,
    input  logic [PTR_W-1:0]  head,
    input  logic              flush,
    output rob_slot_t         slots [DEPTH]
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (flush) begin
                slots[i].valid <= 1'b0;
                slots[i].done  <= 1'b0;
            end else begin
                if (wb_valid && wb_tag == PTR_W'(i) && slots[i].valid) begin
                    slots[i].done    <= 1'b1;
                    slots[i].value   <= wb_value;
                    slots[i].mispred <= wb_mispred;
                end
                if (commit_fire && head == PTR_W'(i)) begin
                    slots[i].valid <= 1'b0;
                    slots[i].done  <= 1'b0;
                end
                if (alloc_fire && tail == PTR_W'(i)) begin
                    slots[i].valid   <= 1'b1;
                    slots[i].done    <= 1'b0;
                    slots[i].mispred <= 1'b0;
                    slots[i].kind    <= alloc_kind;
                    slots[i].dest    <= alloc_dest;
                    slots[i].value   <= '0;
                end
            end
        end

        // R4
        done_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
            slots[i].done |-> slots[i].valid);
    end

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  rob_slot_t         slots [DEPTH],
    input  logic [PTR_W-1:0]  head,
    input  logic [REG_W-1:0]  lookup_reg,
    output logic              hit,
    output logic              ready,
    output logic [PTR_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);
    logic [PTR_W-1:0] best_age;
    logic [PTR_W-1:0] age;

    always_comb begin
        hit      = 1'b0;
        ready    = 1'b0;
        tag      = '0;
        value    = '0;
        best_age = '0;
        age      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age = PTR_W'(PTR_W'(i) - head);
            if (slots[i].valid && writes_reg(slots[i]) &&
                slots[i].dest == lookup_reg && (!hit || age > best_age)) begin
                hit      = 1'b1;
                best_age = age;
                tag      = PTR_W'(i);
                ready    = slots[i].done;
                value    = slots[i].value;
            end
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [PTR_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mispred,
    input  logic [REG_W-1:0]  lookup_reg,
    output logic              lookup_hit,
    output logic              lookup_ready,
    output logic [PTR_W-1:0]  lookup_tag,
    output logic [DATA_W-1:0] lookup_value,
    output logic              commit_fire,
    output logic              commit_wr,
    output logic [REG_W-1:0]  commit_reg,
    output logic [DATA_W-1:0] commit_value,
    output logic              flush
);
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic             full;
    logic             alloc_fire;
    rob_slot_t        slots [DEPTH];
    rob_slot_t        oldest;

    assign oldest      = slots[head];
    assign commit_fire = oldest.valid && oldest.done;
    assign flush       = commit_fire && oldest.kind == KIND_BRANCH && oldest.mispred;
    assign commit_wr   = commit_fire && writes_reg(oldest);
    assign commit_reg  = oldest.dest;
    assign commit_value = oldest.value;

    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .commit_fire(commit_fire),
        .flush      (flush),
        .head       (head),
        .tail       (tail),
        .full       (full)
    );

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .tail       (tail),
        .alloc_kind (rob_kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .wb_mispred (wb_mispred),
        .commit_fire(commit_fire),
        .head       (head),
        .flush      (flush),
        .slots      (slots)
    );

    rob_lookup #(.DEPTH(DEPTH)) u_lookup (
        .slots     (slots),
        .head      (head),
        .lookup_reg(lookup_reg),
        .hit       (lookup_hit),
        .ready     (lookup_ready),
        .tag       (lookup_tag),
        .value     (lookup_value)
    );

    // R6
    commit_wr_kind_chk: assert property (@(posedge clk) disable iff (rst)
        commit_wr |-> commit_fire && !flush);

    // R9
    flush_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !commit_fire && !lookup_hit);

endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
    localparam int DEPTH = 8;
    localparam int PTR_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             alloc_valid = 1'b0;
    logic [1:0]       alloc_kind = 2'd0;
    logic [4:0]       alloc_dest = '0;
    logic             alloc_ready;
    logic [PTR_W-1:0] alloc_tag;
    logic             wb_valid = 1'b0;
    logic [PTR_W-1:0] wb_tag = '0;
    logic [31:0]      wb_value = '0;
    logic             wb_mispred = 1'b0;
    logic [4:0]       lookup_reg = '0;
    logic             lookup_hit, lookup_ready;
    logic [PTR_W-1:0] lookup_tag;
    logic [31:0]      lookup_value;
    logic             commit_fire, commit_wr, flush;
    logic [4:0]       commit_reg;
    logic [31:0]      commit_value;

    rob_core #(.DEPTH(DEPTH)) u_rob_core (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispred(wb_mispred),
        .lookup_reg(lookup_reg), .lookup_hit(lookup_hit), .lookup_ready(lookup_ready),
        .lookup_tag(lookup_tag), .lookup_value(lookup_value),
        .commit_fire(commit_fire), .commit_wr(commit_wr), .commit_reg(commit_reg),
        .commit_value(commit_value), .flush(flush)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          wr;
        logic [4:0]  rg;
        logic [31:0] val;
        bit          fl;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s", rq, what);
        end
    endtask

    task automatic expect_commit(input bit wr, input logic [4:0] rg,
                                 input logic [31:0] val, input bit fl);
        exp_t e;
        e.wr = wr; e.rg = rg; e.val = val; e.fl = fl;
        q.push_back(e);
    endtask

    // Monitor: every retirement is compared against the program-order queue (R5, R6, R9)
    always @(negedge clk) begin
        if (!rst && commit_fire) begin
            if (q.size() == 0) begin
                chk(1'b0, "R5", $sformatf("unexpected retirement reg=%0d actual fire=1 expected fire=0", commit_reg));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(commit_wr == e.wr, "R6",
                    $sformatf("commit_wr actual=%0b expected=%0b", commit_wr, e.wr));
                if (e.wr) begin
                    chk(commit_reg == e.rg && commit_value == e.val, "R5",
                        $sformatf("commit actual=%0d/%h expected=%0d/%h",
                                  commit_reg, commit_value, e.rg, e.val));
                end
                chk(flush == e.fl, "R9",
                    $sformatf("flush actual=%0b expected=%0b", flush, e.fl));
            end
        end
    end

    task automatic alloc1(input logic [1:0] k, input logic [4:0] d,
                          input int exp_tag, input string rq);
        alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d;
        @(negedge clk);
        chk(alloc_ready && alloc_tag == PTR_W'(exp_tag), rq,
            $sformatf("alloc ready/tag actual=%0b/%0d expected=1/%0d", alloc_ready, alloc_tag, exp_tag));
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic wb1(input int t, input logic [31:0] v, input bit m);
        wb_valid = 1'b1; wb_tag = PTR_W'(t); wb_value = v; wb_mispred = m;
        @(posedge clk); #1;
        wb_valid = 1'b0; wb_mispred = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look(input logic [4:0] r, input bit eh, input bit er,
                        input int et, input logic [31:0] ev, input string rq);
        lookup_reg = r;
        @(negedge clk);
        chk(lookup_hit == eh, rq, $sformatf("lookup r%0d hit actual=%0b expected=%0b", r, lookup_hit, eh));
        if (eh) begin
            chk(lookup_ready == er && lookup_tag == PTR_W'(et), rq,
                $sformatf("lookup r%0d ready/tag actual=%0b/%0d expected=%0b/%0d",
                          r, lookup_ready, lookup_tag, er, et));
            if (er)
                chk(lookup_value == ev, rq,
                    $sformatf("lookup r%0d value actual=%h expected=%h", r, lookup_value, ev));
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(alloc_ready && alloc_tag == '0 && !commit_fire && !flush && !lookup_hit, "R1",
            $sformatf("reset ready/tag/fire/flush/hit actual=%0b/%0d/%0b/%0b/%0b expected=1/0/0/0/0",
                      alloc_ready, alloc_tag, commit_fire, flush, lookup_hit));
        @(posedge clk); #1;

        // R2 sequential tags; R7 youngest producer
        alloc1(2'd0, 5'd3, 0, "R2");
        alloc1(2'd0, 5'd3, 1, "R2");
        alloc1(2'd1, 5'd0, 2, "R2");
        look(5'd3, 1, 0, 1, 0, "R7");
        wb1(1, 32'h22, 0);
        lookup_reg = 5'd3;
        @(negedge clk);
        // R5 younger finished slot waits for the oldest
        chk(!commit_fire, "R5", $sformatf("commit_fire actual=%0b expected=0", commit_fire));
        chk(lookup_hit && lookup_ready && lookup_tag == 1 && lookup_value == 32'h22, "R7",
            $sformatf("lookup ready/tag/value actual=%0b/%0d/%h expected=1/1/22",
                      lookup_ready, lookup_tag, lookup_value));
        @(posedge clk); #1;
        expect_commit(1, 5'd3, 32'h11, 0);
        expect_commit(1, 5'd3, 32'h22, 0);
        expect_commit(0, 5'd0, 32'h0, 0);
        wb1(0, 32'h11, 0);
        wb1(2, 32'h0, 0);
        idle(3);
        // R8 retired producer is gone from lookup
        look(5'd3, 0, 0, 0, 0, "R8");

        // R4 writeback to a dead tag (head is now 3)
        wb1(6, 32'h66, 0);
        for (int i = 0; i < DEPTH; i++) alloc1(2'd0, 5'(8 + i), (3 + i) % DEPTH, "R2");
        @(negedge clk);
        chk(!alloc_ready && alloc_tag == 3, "R3",
            $sformatf("full ready/tag actual=%0b/%0d expected=0/3", alloc_ready, alloc_tag));
        @(posedge clk); #1;
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd20;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
        @(negedge clk);
        chk(alloc_tag == 3, "R3", $sformatf("tag after full request actual=%0d expected=3", alloc_tag));
        @(posedge clk); #1;
        look(5'd20, 0, 0, 0, 0, "R3");
        look(5'd11, 1, 0, 6, 0, "R4");

        // R10 allocation and retirement in the same cycle
        expect_commit(1, 5'd8, 32'h100, 0);
        wb1(3, 32'h100, 0);
        expect_commit(1, 5'd9, 32'h101, 0);
        wb1(4, 32'h101, 0);
        alloc1(2'd0, 5'd21, 3, "R10");
        @(negedge clk);
        chk(alloc_ready && alloc_tag == 4, "R10",
            $sformatf("after concurrent alloc ready/tag actual=%0b/%0d expected=1/4", alloc_ready, alloc_tag));
        @(posedge clk); #1;
        look(5'd21, 1, 0, 3, 0, "R7");
        for (int i = 0; i < 6; i++) expect_commit(1, 5'(10 + i), 32'h102 + i, 0);
        expect_commit(1, 5'd21, 32'h1FF, 0);
        for (int i = 0; i < 6; i++) wb1((5 + i) % DEPTH, 32'h102 + i, 0);
        wb1(3, 32'h1FF, 0);
        idle(10);

        // R9 mispredicted branch at head (head is 4)
        alloc1(2'd1, 5'd0, 4, "R2");
        alloc1(2'd0, 5'd7, 5, "R2");
        alloc1(2'd0, 5'd7, 6, "R2");
        wb1(5, 32'h55, 0);
        wb1(6, 32'h56, 0);
        look(5'd7, 1, 1, 6, 32'h56, "R7");
        expect_commit(0, 5'd0, 32'h0, 1);
        wb1(4, 32'h0, 1);
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd30;
        @(negedge clk);
        chk(flush && !alloc_ready, "R9",
            $sformatf("flush/ready actual=%0b/%0b expected=1/0", flush, alloc_ready));
        @(posedge clk); #1;
        alloc_valid = 1'b0;
        @(negedge clk);
        chk(alloc_ready && alloc_tag == 5 && !commit_fire, "R9",
            $sformatf("after flush ready/tag/fire actual=%0b/%0d/%0b expected=1/5/0",
                      alloc_ready, alloc_tag, commit_fire));
        @(posedge clk); #1;
        look(5'd7, 0, 0, 0, 0, "R9");
        look(5'd30, 0, 0, 0, 0, "R9");
        idle(4);
        chk(q.size() == 0, "R5", $sformatf("pending retirements actual=%0d expected=0", q.size()));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule